// File: doc/BRIEF.md
# DTMF Tone Synthesizer with Burst Timer

This block turns a 4-bit key code into a digital dual-tone sample stream for a downstream D/A stage. The code selects one of four row (low group) tones and one of four column (high group) tones. Each channel has its own programmable segment divider. Every tone period is exactly 32 segments, so a tone's frequency is set only by how many clocks one segment lasts. Each divider rollover steps a 5-bit phase through a 32-entry signed sine table. The two channel values are then summed, with the column channel lifted by about 5/4 (roughly 2 dB) to offset line loss on the higher frequencies.

A tone plays only while the tone enable is high. With burst timing off, the tone lasts as long as the enable stays high, and a new code can be written at any time. With burst timing on, a write starts a timed tone and then a silent pause of the same length. After the pause the block raises a one-cycle ready event. The extended-timing input doubles both intervals. Writes made while a burst or its pause is in progress are dropped. A single-tone option sends only the row channel or only the column channel to the output.

Top module: `dtmf_burst_synth`

## Requirements
- R1: The 4-bit code picks its row and column as follows. Codes 1 to 9 walk rows 0..2 and, within each row, columns 0..2 (1 is row 0/column 0, 9 is row 2/column 2). Code 10 is row 3/column 1, code 11 is row 3/column 0, and code 12 is row 3/column 2. Codes 13, 14 and 15 are rows 0, 1 and 2 with column 3, and code 0 is row 3/column 3.
- R2: Segment lengths are round(CLK_HZ/(32*f)) clocks. With CLK_HZ=3579545 this gives 160, 145, 131 and 119 for rows 0..3 (697, 770, 852, 941 Hz) and 93, 84, 76 and 69 for columns 0..3 (1209, 1336, 1477, 1633 Hz). One tone period is 32 segments, and every tone lands within 1.5% of its nominal frequency.
- R3: Channel phase p (0..31) maps to round(127*sin(2*pi*p/32)) as a signed 8-bit value. After n segments a channel's phase is n mod 32, and it starts at 0 when the tone is enabled.
- R4: The dual-tone sample is row_value + floor(5*column_value/4), a signed OUT_W-bit value on mix_out.
- R5: mix_vld pulses for one cycle on each clock edge where a channel feeding the output finishes a segment. mix_out takes its new value on that same edge and holds between pulses.
- R6: With single_en=1, the output carries only the row channel when col_sel=0 (strobing only on row segment ends). With col_sel=1 it carries only the scaled column channel, floor(5*c/4), strobing only on column segment ends.
- R7: While the tone is gated off, mix_out is 0 and mix_vld is 0 from the next edge, and both phases return to 0.
- R8: With burst_en=0, every key_wr latches key_code, including writes made while a tone is playing. The tone then plays for as long as tone_en stays high.
- R9: With burst_en=1, an accepted write at edge 0 gates the tone for edges 1..L, where L = BURST_MS*TICK_DIV clocks. The output is silent for the next L edges, and tx_ready is high for exactly the one cycle after edge 2L.
- R10: With ext_en=1, both the burst interval and the pause interval last 2*BURST_MS*TICK_DIV clocks.
- R11: In burst mode, a write during the tone or the pause is ignored: the code, the timing and the ready event are unchanged. The first write after tx_ready starts a new burst.
- R12: After reset, mix_out is 0 and mix_vld and tx_ready are low, even if tone_en is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | 4 | Key code to synthesize |
| key_wr | input | 1 | Write strobe for key_code |
| tone_en | input | 1 | Enables the tone output |
| burst_en | input | 1 | Selects timed burst/pause operation |
| ext_en | input | 1 | Doubles the burst and pause intervals |
| single_en | input | 1 | Outputs a single group tone |
| col_sel | input | 1 | In single mode: 0 selects row, 1 selects column |
| mix_out | output | OUT_W | Signed mixed sample |
| mix_vld | output | 1 | One-cycle pulse when mix_out updates |
| tx_ready | output | 1 | One-cycle event when a burst's pause ends |

## Verification
The assertions assume that the mode inputs (single_en, col_sel, ext_en, burst_en) stay steady during a tone or burst, and that key_wr is a single-cycle pulse. The stimulus only changes modes while the tone is gated off or the burst timer is idle, and it drops every write strobe after one clock. Writes that must be ignored are issued only while a burst or its pause is running. This lets the bench follow both phases by counting clock edges from the first gated edge.

// File: rtl/dtmf_burst_synth.sv
module dtmf_burst_synth #(
  parameter int CLK_HZ   = 3579545,
  parameter int TICK_DIV = 3580,
  parameter int BURST_MS = 51,
  parameter int OUT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       key_code,
  input  logic             key_wr,
  input  logic             tone_en,
  input  logic             burst_en,
  input  logic             ext_en,
  input  logic             single_en,
  input  logic             col_sel,
  output logic [OUT_W-1:0] mix_out,
  output logic             mix_vld,
  output logic             tx_ready
);

  function automatic int seg_len(input int f);
    return (CLK_HZ + 16 * f) / (32 * f);
  endfunction

  localparam int DIV_W  = $clog2(seg_len(697) + 1);
  localparam int TICK_W = $clog2(TICK_DIV);
  localparam int MS_W   = $clog2(2 * BURST_MS + 1);
  localparam logic [DIV_W-1:0] ROW_LEN [4] = '{DIV_W'(seg_len(697)), DIV_W'(seg_len(770)),
                                              DIV_W'(seg_len(852)), DIV_W'(seg_len(941))};
  localparam logic [DIV_W-1:0] COL_LEN [4] = '{DIV_W'(seg_len(1209)), DIV_W'(seg_len(1336)),
                                              DIV_W'(seg_len(1477)), DIV_W'(seg_len(1633))};

  typedef enum logic [1:0] {IDLE, TONE, PAUSE} bst_t;

  function automatic logic signed [7:0] sine32(input logic [4:0] ph);
    logic [3:0] m;
    logic [7:0] mag;
    m = ph[3] ? 4'(5'd16 - {1'b0, ph[3:0]}) : ph[3:0];
    case (m)
      4'd0:    mag = 8'd0;
      4'd1:    mag = 8'd25;
      4'd2:    mag = 8'd49;
      4'd3:    mag = 8'd71;
      4'd4:    mag = 8'd90;
      4'd5:    mag = 8'd106;
      4'd6:    mag = 8'd117;
      4'd7:    mag = 8'd125;
      default: mag = 8'd127;
    endcase
    return ph[4] ? (8'sd0 - $signed(mag)) : $signed(mag);
  endfunction

  logic [3:0]       code_q;
  logic [3:0]       row_oh, col_oh;
  logic [DIV_W-1:0] row_len, col_len;
  logic [DIV_W-1:0] row_cnt, col_cnt;
  logic [4:0]       row_ph, col_ph, row_ph_n, col_ph_n;
  logic             row_adv, col_adv, out_adv, gate, accept;
  bst_t             st;
  logic [TICK_W-1:0] tick;
  logic [MS_W-1:0]  ms, ms_len;
  logic signed [7:0]  rv, cv;
  logic signed [10:0] c5, cs;
  logic signed [11:0] rpart, cpart;
  logic [OUT_W-1:0] mix;

  // key code to one-of-four row and column selects
  always_comb begin
    row_oh = 4'b0;
    col_oh = 4'b0;
    case (code_q)
      4'd1:  begin row_oh[0] = 1'b1; col_oh[0] = 1'b1; end
      4'd2:  begin row_oh[0] = 1'b1; col_oh[1] = 1'b1; end
      4'd3:  begin row_oh[0] = 1'b1; col_oh[2] = 1'b1; end
      4'd4:  begin row_oh[1] = 1'b1; col_oh[0] = 1'b1; end
      4'd5:  begin row_oh[1] = 1'b1; col_oh[1] = 1'b1; end
      4'd6:  begin row_oh[1] = 1'b1; col_oh[2] = 1'b1; end
      4'd7:  begin row_oh[2] = 1'b1; col_oh[0] = 1'b1; end
      4'd8:  begin row_oh[2] = 1'b1; col_oh[1] = 1'b1; end
      4'd9:  begin row_oh[2] = 1'b1; col_oh[2] = 1'b1; end
      4'd10: begin row_oh[3] = 1'b1; col_oh[1] = 1'b1; end
      4'd11: begin row_oh[3] = 1'b1; col_oh[0] = 1'b1; end
      4'd12: begin row_oh[3] = 1'b1; col_oh[2] = 1'b1; end
      4'd13: begin row_oh[0] = 1'b1; col_oh[3] = 1'b1; end
      4'd14: begin row_oh[1] = 1'b1; col_oh[3] = 1'b1; end
      4'd15: begin row_oh[2] = 1'b1; col_oh[3] = 1'b1; end
      default: begin row_oh[3] = 1'b1; col_oh[3] = 1'b1; end
    endcase
  end

  always_comb begin
    row_len = '0;
    col_len = '0;
    for (int i = 0; i < 4; i++) begin
      row_len = row_len | (ROW_LEN[i] & {DIV_W{row_oh[i]}});
      col_len = col_len | (COL_LEN[i] & {DIV_W{col_oh[i]}});
    end
  end

  // burst / pause timer
  assign accept = key_wr && (!burst_en || st == IDLE);
  assign ms_len = ext_en ? MS_W'(2 * BURST_MS) : MS_W'(BURST_MS);
  assign gate   = tone_en && (!burst_en || st == TONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= 4'd0;
      st       <= IDLE;
      tick     <= '0;
      ms       <= '0;
      tx_ready <= 1'b0;
    end else begin
      tx_ready <= 1'b0;
      if (accept) code_q <= key_code;
      if (!burst_en) begin
        st   <= IDLE;
        tick <= '0;
        ms   <= '0;
      end else if (st == IDLE) begin
        if (key_wr) begin
          st   <= TONE;
          tick <= '0;
          ms   <= '0;
        end
      end else if (tick == TICK_W'(TICK_DIV - 1)) begin
        tick <= '0;
        if (ms >= ms_len - 1'b1) begin
          ms       <= '0;
          st       <= (st == TONE) ? PAUSE : IDLE;
          tx_ready <= (st == PAUSE);
        end else begin
          ms <= ms + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // segment dividers, phases and mixing
  assign row_adv  = row_cnt >= row_len - 1'b1;
  assign col_adv  = col_cnt >= col_len - 1'b1;
  assign row_ph_n = row_ph + 5'(row_adv);
  assign col_ph_n = col_ph + 5'(col_adv);
  assign out_adv  = single_en ? (col_sel ? col_adv : row_adv) : (row_adv | col_adv);

  assign rv    = sine32(row_ph_n);
  assign cv    = sine32(col_ph_n);
  assign c5    = 11'(cv) * 11'sd5;
  assign cs    = c5 >>> 2;
  assign rpart = (single_en && col_sel) ? 12'sd0 : 12'(rv);
  assign cpart = (single_en && !col_sel) ? 12'sd0 : 12'(cs);
  assign mix   = OUT_W'(rpart + cpart);

  always_ff @(posedge clk) begin
    if (!rst_n || !gate) begin
      row_cnt <= '0;
      col_cnt <= '0;
      row_ph  <= '0;
      col_ph  <= '0;
      mix_out <= '0;
      mix_vld <= 1'b0;
    end else begin
      row_cnt <= row_adv ? '0 : row_cnt + 1'b1;
      col_cnt <= col_adv ? '0 : col_cnt + 1'b1;
      row_ph  <= row_ph_n;
      col_ph  <= col_ph_n;
      mix_vld <= out_adv;
      if (out_adv) mix_out <= mix;
    end
  end

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R9
  ready_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(st) == PAUSE);

  // R7
  silent_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (mix_out == '0 && !mix_vld));

  // R6
  single_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && single_en && !col_sel && !row_adv) |=> $stable(mix_out));

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && st != IDLE && key_wr) |=> $stable(code_q));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> (row_ph == $past(row_ph) || row_ph == 5'($past(row_ph) + 5'd1)));

endmodule

// File: tb/dtmf_burst_synth_tb.sv
`timescale 1ns/1ps
module dtmf_burst_synth_tb;
  localparam int TICK = 40;
  localparam int MSN  = 5;
  localparam int L    = TICK * MSN;

  // code, row segment length, column segment length (R1, R2)
  localparam int VEC [16][3] = '{
    '{1, 160, 93}, '{2, 160, 84}, '{3, 160, 76}, '{4, 145, 93},
    '{5, 145, 84}, '{6, 145, 76}, '{7, 131, 93}, '{8, 131, 84},
    '{9, 131, 76}, '{10, 119, 84}, '{11, 119, 93}, '{12, 119, 76},
    '{13, 160, 69}, '{14, 145, 69}, '{15, 131, 69}, '{0, 119, 69}};

  logic clk = 0, rst_n = 0;
  logic [3:0] key_code = 0;
  logic key_wr = 0, tone_en = 0, burst_en = 0, ext_en = 0, single_en = 0, col_sel = 0;
  logic [9:0] mix_out;
  logic mix_vld, tx_ready;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dtmf_burst_synth #(.TICK_DIV(TICK), .BURST_MS(MSN)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_wr(key_wr), .tone_en(tone_en),
    .burst_en(burst_en), .ext_en(ext_en), .single_en(single_en), .col_sel(col_sel),
    .mix_out(mix_out), .mix_vld(mix_vld), .tx_ready(tx_ready));

  function automatic int bsin(input int k);
    real v;
    v = 127.0 * $sin(6.283185307179586 * k / 32.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int bcol(input int k);
    return (5 * bsin(k)) >>> 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_tone(input int code, input bit sgl, input bit csel, input int rdiv,
                          input int cdiv, input int n, input bit live, input string tag);
    int bad = 0, fa = 0, fe = 0;
    single_en = sgl; col_sel = csel; burst_en = 0;
    if (live) begin
      tone_en = 1;
      repeat (10) step();
    end else tone_en = 0;
    key_code = 4'(code); key_wr = 1;
    step();
    key_wr = 0;
    if (live) begin
      tone_en = 0;
      step();
    end
    tone_en = 1;
    for (int e = 1; e <= n; e++) begin
      int rp, cp, ex;
      bit sb;
      step();
      rp = (e / rdiv) % 32;
      cp = (e / cdiv) % 32;
      if (sgl && !csel) begin ex = bsin(rp); sb = (e % rdiv == 0); end
      else if (sgl) begin ex = bcol(cp); sb = (e % cdiv == 0); end
      else begin ex = bsin(rp) + bcol(cp); sb = (e % rdiv == 0) || (e % cdiv == 0); end
      if ($signed(mix_out) != ex || mix_vld != sb) begin
        if (bad == 0) begin fa = $signed(mix_out); fe = ex; end
        bad++;
      end
    end
    chk(bad == 0, tag, fa, fe);
    tone_en = 0;
    step();
    // R7
    chk(mix_out == 0 && !mix_vld, "R7 gated off", $signed(mix_out), 0);
  endtask

  task automatic run_burst(input int code, input bit ext, input int rdiv, input int cdiv,
                           input int xk, input int xcode, input string tag);
    int len, bad = 0, badr = 0, fa = 0, fe = 0, rk = -1;
    len = ext ? 2 * L : L;
    single_en = 0; ext_en = ext; burst_en = 1; tone_en = 1;
    key_code = 4'(code); key_wr = 1;
    step();
    key_wr = 0;
    for (int k = 1; k <= 2 * len + 4; k++) begin
      int ex;
      bit sb;
      step();
      if (k <= len) begin
        ex = bsin((k / rdiv) % 32) + bcol((k / cdiv) % 32);
        sb = (k % rdiv == 0) || (k % cdiv == 0);
      end else begin
        ex = 0; sb = 0;
      end
      if ($signed(mix_out) != ex || mix_vld != sb) begin
        if (bad == 0) begin fa = $signed(mix_out); fe = ex; end
        bad++;
      end
      if (tx_ready != (k == 2 * len)) begin
        badr++;
        if (rk < 0) rk = k;
      end
      key_wr = (k == xk);
      key_code = (k == xk) ? 4'(xcode) : 4'(code);
    end
    chk(bad == 0, {tag, " tone/pause"}, fa, fe);
    chk(badr == 0, {tag, " ready"}, rk, 2 * len);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    tone_en = 1;
    repeat (4) step();
    // R12
    chk(mix_out == 0, "R12 reset mix_out", $signed(mix_out), 0);
    chk(!mix_vld, "R12 reset mix_vld", mix_vld, 0);
    chk(!tx_ready, "R12 reset tx_ready", tx_ready, 0);
    tone_en = 0;
    rst_n = 1;
    step();

    // R1 R2 R4 R5: every key code in dual-tone mode
    for (int i = 0; i < 16; i++)
      run_tone(VEC[i][0], 0, 0, VEC[i][1], VEC[i][2], 1200, 0, "R1 R4 R5 dual code");

    // R6 R2 R3 R8: full periods of single tones, long sustain
    run_tone(1, 1, 0, 160, 93, 5200, 0, "R6 R2 R3 single row");
    run_tone(13, 1, 1, 160, 69, 2300, 0, "R6 R2 single column");
    run_tone(0, 1, 0, 119, 69, 3900, 0, "R6 R3 single row 941");
    // R8: write accepted while a tone plays
    run_tone(12, 0, 0, 119, 76, 900, 1, "R8 live write");

    // R9 R11: write during tone ignored
    run_burst(7, 0, 131, 93, 50, 2, "R9 R11 burst");
    // R10 R11: extended timing, write during pause ignored
    run_burst(0, 1, 119, 69, 2 * L + 10, 3, "R10 R11 extended");
    // R11: next write after ready starts a new burst
    run_burst(9, 0, 131, 76, 0, 0, "R11 rearm");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule